// File: doc/BRIEF.md
# Quad-lane serial flash command sequencer

This block runs one complete serial memory transaction at a time. A compact descriptor sets what the transaction looks like. It holds an opcode byte and a transfer direction. It gives a lane width for each of four phases: opcode, address, mode (alternate) bytes and data. It also gives the address and mode byte counts and the number of idle dummy clocks. Because every phase has its own width and length, one engine can issue the command sets of both NOR and NAND parts, from a one-byte write enable up to a four-lane read that carries an address and a continuation byte.

The block generates chip select, a serial clock at half the system clock, and four IO lanes. Each lane has its own output, output enable and input. Write data is pulled one byte at a time from a byte port, with a take strobe. Read data is handed out one byte at a time with a valid strobe. A start pulse latches the descriptor together with the address, the mode value and the data byte count. A done pulse marks the end of the transaction.

Top module: `qspi_cmd_seq`

## Requirements
- R1: While reset is active and after its release, chip select is high, the serial clock is low, all output enables are 0, and done, rd_valid and wr_take are 0.
- R2: Phases run in a fixed order: opcode, address, mode bytes, dummy clocks, data. A phase whose lane code is 0 is absent. Dummy clocks are absent when their count is 0. An absent phase is skipped with no clocks in its place. If every phase is absent, chip select never falls, but done still pulses.
- R3: Lane code 1 uses one line, 2 uses two lines and 3 uses four lines. Bits go MSB first. One-line output is on IO0 and one-line input is on IO1. Two-line mode carries the earlier bit on IO1. Four-line mode carries the earlier bit on IO3.
- R4: The address and mode byte-count fields hold count minus one (0..3). The phase sends that many low-order bytes of the 32-bit value, with the most significant byte first.
- R5: During the dummy clocks the serial clock keeps toggling, the number of clocks equals the programmed count, and no lane is driven.
- R6: Direction 0 reads: the data lanes are sampled on each rising clock, and rd_valid pulses for one cycle with each completed byte. Direction 1 writes: wr_take pulses in the cycle in which a wr_data byte is consumed, and that byte is shifted out.
- R7: The serial clock runs at half the system clock and rests low. IO outputs and enables change only together with a falling clock edge, never with a rising one.
- R8: Chip select stays low from the first clock through the last clock. It then stays high for at least two system cycles. Done pulses for one cycle, in the second cycle after chip select rises.
- R9: A start pulse that arrives while a transaction or its chip-select gap is in progress is ignored.
- R10: A data byte count of 0 removes the data phase, even when the data lane code is non-zero.
- R11: An output enable is 1 only while its lane drives opcode, address, mode or write-data bits. All enables are 0 during read data and while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, latches all transaction inputs |
| op_code_i | input | 8 | Opcode byte |
| op_dir_i | input | 1 | 0 read, 1 write |
| cmd_lanes_i | input | 2 | Opcode lane code |
| adr_lanes_i | input | 2 | Address lane code |
| adr_len_i | input | 2 | Address bytes minus one |
| alt_lanes_i | input | 2 | Mode-byte lane code |
| alt_len_i | input | 2 | Mode bytes minus one |
| dummy_i | input | 5 | Dummy clock count |
| dat_lanes_i | input | 2 | Data lane code |
| xfer_len_i | input | 16 | Data byte count |
| adr_i | input | 32 | Address value |
| alt_i | input | 32 | Mode-byte value |
| wr_data_i | input | 8 | Next write byte |
| wr_take_o | output | 1 | Write byte consumed this cycle |
| rd_data_o | output | 8 | Last completed read byte |
| rd_valid_o | output | 1 | Read byte valid pulse |
| done_o | output | 1 | Transaction finished pulse |
| cs_n_o | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock |
| io_out_o | output | 4 | Lane output values |
| io_oe_o | output | 4 | Lane output enables |
| io_in_i | input | 4 | Lane input values |

## Verification
Two events can land in the same cycle. The first is the falling clock that ends one phase and loads the first byte of the next. The second is, in a write, the consumption of a new wr_data byte. The bench provokes this at every phase boundary that leads into write data. It also provokes it at every byte boundary inside the data phase, with one, two and four lanes. It judges the case against a behavioural per-cycle model: wr_take must appear exactly in the high half of the last clock before the new byte, and the new byte's bits must appear on the lanes in the very next cycle. A second collision, a start pulse during a running read, is judged by requiring that the read's clock, lane and byte sequence continues unchanged.

// File: rtl/qseq_pkg.sv
package qseq_pkg;

  typedef enum logic [2:0] {
    PH_CMD  = 3'd0,
    PH_ADR  = 3'd1,
    PH_ALT  = 3'd2,
    PH_DUM  = 3'd3,
    PH_DAT  = 3'd4,
    PH_NONE = 3'd7
  } qseq_ph_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } qseq_st_e;

  typedef struct packed {
    logic [7:0] op;
    logic       dir;
    logic [1:0] cmd_ln;
    logic [1:0] adr_ln;
    logic [1:0] alt_ln;
    logic [1:0] dat_ln;
  } qseq_desc_t;

  // Number of lanes for a lane code.
  function automatic logic [2:0] lane_cnt(input logic [1:0] code);
    case (code)
      2'd1:    lane_cnt = 3'd1;
      2'd2:    lane_cnt = 3'd2;
      2'd3:    lane_cnt = 3'd4;
      default: lane_cnt = 3'd0;
    endcase
  endfunction

  // Serial clocks per byte, minus one, for a lane code.
  function automatic logic [2:0] clk_per_byte_m1(input logic [1:0] code);
    case (code)
      2'd1:    clk_per_byte_m1 = 3'd7;
      2'd2:    clk_per_byte_m1 = 3'd3;
      2'd3:    clk_per_byte_m1 = 3'd1;
      default: clk_per_byte_m1 = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/qseq_rst_sync.sv
module qseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/qseq_phase_pick.sv
module qseq_phase_pick
  import qseq_pkg::*;
#(
  parameter int NPH = 5
) (
  input  qseq_ph_e       cur_i,
  input  logic [NPH-1:0] present_i,
  output qseq_ph_e       nxt_o
);
  // First present phase strictly after cur_i, PH_NONE meaning "before all".
  always_comb begin
    nxt_o = PH_NONE;
    for (int k = NPH - 1; k >= 0; k--) begin
      if (present_i[k] && (cur_i == PH_NONE || k > int'(cur_i))) begin
        nxt_o = qseq_ph_e'(3'(k));
      end
    end
  end
endmodule

// File: rtl/qseq_lane_mux.sv
module qseq_lane_mux (
  input  logic [1:0] lanes_i,
  input  logic       drive_i,
  input  logic [7:0] sh_i,
  input  logic [7:0] rsh_i,
  input  logic [3:0] io_in_i,
  output logic [3:0] out_o,
  output logic [3:0] oe_o,
  output logic [7:0] rd_next_o
);
  always_comb begin
    out_o = 4'b0000;
    oe_o  = 4'b0000;
    if (drive_i) begin
      case (lanes_i)
        2'd1: begin out_o = {3'b000, sh_i[7]};   oe_o = 4'b0001; end
        2'd2: begin out_o = {2'b00, sh_i[7:6]};  oe_o = 4'b0011; end
        2'd3: begin out_o = sh_i[7:4];           oe_o = 4'b1111; end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (lanes_i)
      2'd1:    rd_next_o = {rsh_i[6:0], io_in_i[1]};
      2'd2:    rd_next_o = {rsh_i[5:0], io_in_i[1:0]};
      2'd3:    rd_next_o = {rsh_i[3:0], io_in_i[3:0]};
      default: rd_next_o = rsh_i;
    endcase
  end
endmodule

// File: rtl/qspi_cmd_seq.sv
module qspi_cmd_seq
  import qseq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int LENW = 16,
  parameter int DUMW = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [7:0]              op_code_i,
  input  logic                    op_dir_i,
  input  logic [1:0]              cmd_lanes_i,
  input  logic [1:0]              adr_lanes_i,
  input  logic [$clog2(AW/8)-1:0] adr_len_i,
  input  logic [1:0]              alt_lanes_i,
  input  logic [$clog2(AW/8)-1:0] alt_len_i,
  input  logic [DUMW-1:0]         dummy_i,
  input  logic [1:0]              dat_lanes_i,
  input  logic [LENW-1:0]         xfer_len_i,
  input  logic [AW-1:0]           adr_i,
  input  logic [AW-1:0]           alt_i,
  input  logic [7:0]              wr_data_i,
  output logic                    wr_take_o,
  output logic [7:0]              rd_data_o,
  output logic                    rd_valid_o,
  output logic                    done_o,
  output logic                    cs_n_o,
  output logic                    sck_o,
  output logic [3:0]              io_out_o,
  output logic [3:0]              io_oe_o,
  input  logic [3:0]              io_in_i
);
  localparam int AB  = AW / 8;
  localparam int ABW = $clog2(AB);
  localparam int CLW = (DUMW > 3) ? DUMW : 3;
  localparam int NPH = 5;

  logic rst_s;
  qseq_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .arst_n(rst_n), .rst_no(rst_s));

  qseq_st_e        st_q, st_n;
  qseq_ph_e        ph_q, ph_n;
  logic            sck_q, sck_n;
  logic [CLW-1:0]  cl_q, cl_n;
  logic [LENW-1:0] bl_q, bl_n;
  logic [7:0]      sh_q, sh_n, rsh_q, rsh_n, rdd_q, rdd_n;
  logic            rdv_q, rdv_n;
  logic            gap_q, gap_n;
  logic [AW-1:0]   adr_q, adr_n, alt_q, alt_n;
  qseq_desc_t      d_q, d_n;
  logic [ABW-1:0]  al_q, al_n, tl_q, tl_n;
  logic [DUMW-1:0] dm_q, dm_n;
  logic [LENW-1:0] ln_q, ln_n;

  // Active descriptor: ports while idle (for the start cycle), latched otherwise.
  qseq_desc_t      d_in, d_a;
  logic [ABW-1:0]  al_a, tl_a;
  logic [DUMW-1:0] dm_a;
  logic [LENW-1:0] ln_a;
  logic [AW-1:0]   adr_a, alt_a;
  logic            idle;

  assign idle = (st_q == ST_IDLE);

  always_comb begin
    d_in.op     = op_code_i;
    d_in.dir    = op_dir_i;
    d_in.cmd_ln = cmd_lanes_i;
    d_in.adr_ln = adr_lanes_i;
    d_in.alt_ln = alt_lanes_i;
    d_in.dat_ln = dat_lanes_i;
  end

  assign d_a   = idle ? d_in : d_q;
  assign al_a  = idle ? adr_len_i : al_q;
  assign tl_a  = idle ? alt_len_i : tl_q;
  assign dm_a  = idle ? dummy_i : dm_q;
  assign ln_a  = idle ? xfer_len_i : ln_q;
  assign adr_a = idle ? (adr_i << (8 * (AB - 1 - int'(adr_len_i)))) : adr_q;
  assign alt_a = idle ? (alt_i << (8 * (AB - 1 - int'(alt_len_i)))) : alt_q;

  // Phase presence and next-phase selection.
  logic [NPH-1:0] present;
  qseq_ph_e       nxt, cur_sel, tgt;

  assign present[0] = |d_a.cmd_ln;
  assign present[1] = |d_a.adr_ln;
  assign present[2] = |d_a.alt_ln;
  assign present[3] = |dm_a;
  assign present[4] = (|d_a.dat_ln) && (|ln_a);
  assign cur_sel    = idle ? PH_NONE : ph_q;

  qseq_phase_pick #(.NPH(NPH)) u_pick (
    .cur_i    (cur_sel),
    .present_i(present),
    .nxt_o    (nxt)
  );

  // Same phase continues with another byte, or move to the next phase.
  logic same;
  assign same = (st_q == ST_RUN) && (cl_q == '0) && (ph_q != PH_DUM) && (bl_q != '0);
  assign tgt  = same ? ph_q : nxt;

  logic [1:0]      tgt_ln, cur_ln;
  logic [CLW-1:0]  ld_cl;
  logic [LENW-1:0] ld_bl;
  logic [7:0]      ld_sh;

  always_comb begin
    case (tgt)
      PH_CMD:  tgt_ln = d_a.cmd_ln;
      PH_ADR:  tgt_ln = d_a.adr_ln;
      PH_ALT:  tgt_ln = d_a.alt_ln;
      PH_DAT:  tgt_ln = d_a.dat_ln;
      default: tgt_ln = 2'd0;
    endcase
    case (ph_q)
      PH_CMD:  cur_ln = d_q.cmd_ln;
      PH_ADR:  cur_ln = d_q.adr_ln;
      PH_ALT:  cur_ln = d_q.alt_ln;
      PH_DAT:  cur_ln = d_q.dat_ln;
      default: cur_ln = 2'd0;
    endcase
  end

  always_comb begin
    if (tgt == PH_DUM) ld_cl = CLW'(dm_a) - CLW'(1);
    else               ld_cl = CLW'(clk_per_byte_m1(tgt_ln));
    if (same) ld_bl = bl_q - LENW'(1);
    else begin
      case (tgt)
        PH_ADR:  ld_bl = LENW'(al_a);
        PH_ALT:  ld_bl = LENW'(tl_a);
        PH_DAT:  ld_bl = ln_a - LENW'(1);
        default: ld_bl = '0;
      endcase
    end
    case (tgt)
      PH_CMD:  ld_sh = d_a.op;
      PH_ADR:  ld_sh = adr_a[AW-1 -: 8];
      PH_ALT:  ld_sh = alt_a[AW-1 -: 8];
      PH_DAT:  ld_sh = wr_data_i;
      default: ld_sh = 8'h00;
    endcase
  end

  // Lane drive and input gathering.
  logic       drive;
  logic [7:0] rd_next;

  assign drive = (st_q == ST_RUN) &&
                 ((ph_q == PH_CMD) || (ph_q == PH_ADR) || (ph_q == PH_ALT) ||
                  ((ph_q == PH_DAT) && d_q.dir));

  qseq_lane_mux u_lanes (
    .lanes_i  (cur_ln),
    .drive_i  (drive),
    .sh_i     (sh_q),
    .rsh_i    (rsh_q),
    .io_in_i  (io_in_i),
    .out_o    (io_out_o),
    .oe_o     (io_oe_o),
    .rd_next_o(rd_next)
  );

  // Next-state logic.
  logic take;

  always_comb begin
    st_n  = st_q;   ph_n  = ph_q;   sck_n = sck_q;
    cl_n  = cl_q;   bl_n  = bl_q;   sh_n  = sh_q;
    rsh_n = rsh_q;  rdd_n = rdd_q;  rdv_n = 1'b0;
    gap_n = gap_q;  adr_n = adr_q;  alt_n = alt_q;
    d_n   = d_q;    al_n  = al_q;   tl_n  = tl_q;
    dm_n  = dm_q;   ln_n  = ln_q;   take  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          d_n   = d_in;      al_n = adr_len_i; tl_n = alt_len_i;
          dm_n  = dummy_i;   ln_n = xfer_len_i;
          adr_n = adr_a;     alt_n = alt_a;
          if (nxt == PH_NONE) begin
            st_n  = ST_GAP;
            gap_n = 1'b0;
          end else begin
            st_n  = ST_RUN;
            ph_n  = nxt;
            sck_n = 1'b0;
            cl_n  = ld_cl;
            bl_n  = ld_bl;
            sh_n  = ld_sh;
            if (nxt == PH_ADR) adr_n = adr_a << 8;
            if (nxt == PH_ALT) alt_n = alt_a << 8;
            take  = (nxt == PH_DAT) && d_in.dir;
          end
        end
      end
      ST_RUN: begin
        if (!sck_q) begin
          sck_n = 1'b1;
          if (ph_q == PH_DAT && !d_q.dir) begin
            rsh_n = rd_next;
            if (cl_q == '0) begin
              rdv_n = 1'b1;
              rdd_n = rd_next;
            end
          end
        end else begin
          sck_n = 1'b0;
          if (cl_q != '0) begin
            cl_n = cl_q - CLW'(1);
            sh_n = sh_q << lane_cnt(cur_ln);
          end else if (tgt == PH_NONE) begin
            st_n  = ST_GAP;
            gap_n = 1'b0;
            ph_n  = PH_NONE;
          end else begin
            ph_n = tgt;
            cl_n = ld_cl;
            bl_n = ld_bl;
            sh_n = ld_sh;
            if (tgt == PH_ADR) adr_n = adr_q << 8;
            if (tgt == PH_ALT) alt_n = alt_q << 8;
            take = (tgt == PH_DAT) && d_q.dir;
          end
        end
      end
      ST_GAP: begin
        gap_n = 1'b1;
        if (gap_q) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q  <= ST_IDLE; ph_q  <= PH_NONE; sck_q <= 1'b0;
      cl_q  <= '0;      bl_q  <= '0;      sh_q  <= '0;
      rsh_q <= '0;      rdd_q <= '0;      rdv_q <= 1'b0;
      gap_q <= 1'b0;    adr_q <= '0;      alt_q <= '0;
      d_q   <= '0;      al_q  <= '0;      tl_q  <= '0;
      dm_q  <= '0;      ln_q  <= '0;
    end else begin
      st_q  <= st_n;    ph_q  <= ph_n;    sck_q <= sck_n;
      cl_q  <= cl_n;    bl_q  <= bl_n;    sh_q  <= sh_n;
      rsh_q <= rsh_n;   rdd_q <= rdd_n;   rdv_q <= rdv_n;
      gap_q <= gap_n;   adr_q <= adr_n;   alt_q <= alt_n;
      d_q   <= d_n;     al_q  <= al_n;    tl_q  <= tl_n;
      dm_q  <= dm_n;    ln_q  <= ln_n;
    end
  end

  assign cs_n_o     = (st_q != ST_RUN);
  assign sck_o      = sck_q;
  assign done_o     = (st_q == ST_GAP) && gap_q;
  assign rd_valid_o = rdv_q;
  assign rd_data_o  = rdd_q;
  assign wr_take_o  = take;

endmodule

// File: rtl/qseq_checker.sv
module qseq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sck,
  input logic [3:0] io_out,
  input logic [3:0] io_oe,
  input logic       done,
  input logic       rd_valid,
  input logic       wr_take
);
  // R7
  sck_rise_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> ($stable(io_out) && $stable(io_oe)));

  // R7
  sck_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && $past(cs_n)));

  // R11
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (io_oe == 4'b0000));

  // R3
  oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b0011) || (io_oe == 4'b1111));

  // R6
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!cs_n && sck && (io_oe == 4'b0000)));

  // R6
  wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_take && !cs_n) |-> sck);
endmodule

bind qspi_cmd_seq qseq_checker i_qseq_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_n    (cs_n_o),
  .sck     (sck_o),
  .io_out  (io_out_o),
  .io_oe   (io_oe_o),
  .done    (done_o),
  .rd_valid(rd_valid_o),
  .wr_take (wr_take_o)
);

// File: tb/test_qspi_cmd_seq.sv
module test_qspi_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [7:0]  op_code_i;
  logic        op_dir_i;
  logic [1:0]  cmd_lanes_i, adr_lanes_i, adr_len_i, alt_lanes_i, alt_len_i, dat_lanes_i;
  logic [4:0]  dummy_i;
  logic [15:0] xfer_len_i;
  logic [31:0] adr_i, alt_i;
  logic [7:0]  wr_data_i;
  logic        wr_take_o;
  logic [7:0]  rd_data_o;
  logic        rd_valid_o, done_o, cs_n_o, sck_o;
  logic [3:0]  io_out_o, io_oe_o, io_in_i;

  always #2 clk = ~clk;

  qspi_cmd_seq i_qspi_cmd_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_code_i(op_code_i),
    .op_dir_i(op_dir_i), .cmd_lanes_i(cmd_lanes_i), .adr_lanes_i(adr_lanes_i),
    .adr_len_i(adr_len_i), .alt_lanes_i(alt_lanes_i), .alt_len_i(alt_len_i),
    .dummy_i(dummy_i), .dat_lanes_i(dat_lanes_i), .xfer_len_i(xfer_len_i),
    .adr_i(adr_i), .alt_i(alt_i), .wr_data_i(wr_data_i), .wr_take_o(wr_take_o),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .done_o(done_o),
    .cs_n_o(cs_n_o), .sck_o(sck_o), .io_out_o(io_out_o), .io_oe_o(io_oe_o),
    .io_in_i(io_in_i)
  );

  typedef struct {
    bit       cs, sck, dn, rdv, wt;
    bit [3:0] oe, o, din;
    bit [7:0] rdd;
  } rec_t;

  rec_t       q[$];
  bit [7:0]   wbytes[$];
  bit [7:0]   rbytes[$];
  int         n_run = 0, n_fail = 0, cyc = 0, widx = 0;
  bit         req = 0, ign = 0, wt_seen = 0, finished = 0;
  string      ttag = "R1";

  bit [7:0]  b_op;   bit b_dir;
  bit [1:0]  b_cl, b_al, b_alen, b_tl, b_tlen, b_dl;
  bit [4:0]  b_dum;  bit [15:0] b_len;
  bit [31:0] b_adr, b_alt;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h (cycle %0d)", tag, ttag, what, act, exp, cyc);
    end
  endtask

  task automatic push_clk(input bit [3:0] oe, input bit [3:0] o, input bit [3:0] din,
                          input bit rdv, input bit [7:0] rdd);
    rec_t r;
    r = '{cs:0, sck:0, dn:0, rdv:0, wt:0, oe:oe, o:o, din:din, rdd:8'h00};
    q.push_back(r);
    r.sck = 1; r.rdv = rdv; r.rdd = rdd;
    q.push_back(r);
  endtask

  function automatic int kof(input bit [1:0] code);
    return (code == 2'd1) ? 1 : (code == 2'd2) ? 2 : 4;
  endfunction

  task automatic emit(input bit [7:0] b, input int k, input bit drv);
    for (int j = 0; j < 8 / k; j++) begin
      bit [3:0] bits;
      bits = 4'((b >> (8 - k * (j + 1))) & ((1 << k) - 1));
      if (drv) push_clk(4'((1 << k) - 1), bits, 4'b0, 0, 8'h00);
      else     push_clk(4'b0, 4'b0, (k == 1) ? 4'(bits << 1) : bits, (j == 8 / k - 1), b);
    end
  endtask

  task automatic build();
    rec_t g;
    q.delete();
    widx = 0;
    if (b_cl != 0) emit(b_op, kof(b_cl), 1);
    if (b_al != 0) for (int j = int'(b_alen); j >= 0; j--) emit(8'(b_adr >> (8 * j)), kof(b_al), 1);
    if (b_tl != 0) for (int j = int'(b_tlen); j >= 0; j--) emit(8'(b_alt >> (8 * j)), kof(b_tl), 1);
    for (int d = 0; d < int'(b_dum); d++) push_clk(4'b0, 4'b0, 4'b0, 0, 8'h00);
    if (b_dl != 0 && b_len != 0) begin
      for (int i = 0; i < int'(b_len); i++) begin
        if (b_dir) begin
          if (q.size() > 0) q[q.size() - 1].wt = 1;
          emit(wbytes[i], kof(b_dl), 1);
        end else emit(rbytes[i], kof(b_dl), 0);
      end
    end
    g = '{cs:1, sck:0, dn:0, rdv:0, wt:0, oe:4'b0, o:4'b0, din:4'b0, rdd:8'h00};
    q.push_back(g);
    g.dn = 1;
    q.push_back(g);
  endtask

  // Per-cycle reference comparison, stimulus driving.
  always @(negedge clk) begin
    rec_t c;
    if (!finished) begin
      if (q.size() > 0) c = q.pop_front();
      else c = '{cs:1, sck:0, dn:0, rdv:0, wt:0, oe:4'b0, o:4'b0, din:4'b0, rdd:8'h00};
      chk(cs_n_o == c.cs, "R8", "cs_n", int'(cs_n_o), int'(c.cs));
      chk(sck_o == c.sck, "R7", "sck", int'(sck_o), int'(c.sck));
      chk(io_oe_o == c.oe, "R11", "io_oe", int'(io_oe_o), int'(c.oe));
      chk((io_out_o & c.oe) == (c.o & c.oe), "R3", "io_out", int'(io_out_o & c.oe), int'(c.o & c.oe));
      chk(done_o == c.dn, "R8", "done", int'(done_o), int'(c.dn));
      chk(rd_valid_o == c.rdv, "R6", "rd_valid", int'(rd_valid_o), int'(c.rdv));
      if (c.rdv) chk(rd_data_o == c.rdd, "R6", "rd_data", int'(rd_data_o), int'(c.rdd));
      chk(wr_take_o == c.wt, "R6", "wr_take", int'(wr_take_o), int'(c.wt));
      io_in_i = c.din;
      if (wt_seen) widx++;
      wt_seen = wr_take_o;
      if (req) begin
        op_code_i = b_op; op_dir_i = b_dir; cmd_lanes_i = b_cl; adr_lanes_i = b_al;
        adr_len_i = b_alen; alt_lanes_i = b_tl; alt_len_i = b_tlen; dummy_i = b_dum;
        dat_lanes_i = b_dl; xfer_len_i = b_len; adr_i = b_adr; alt_i = b_alt;
        start_i = 1;
        if (!ign) begin
          build();
          wt_seen = 0;
        end
        ign = 0;
        req = 0;
      end else start_i = 0;
      wr_data_i = (widx < wbytes.size()) ? wbytes[widx] : 8'h00;
    end
  end

  task automatic set_desc(input bit [7:0] op, input bit dir, input bit [1:0] cl,
                          input bit [1:0] al, input bit [1:0] alen, input bit [1:0] tl,
                          input bit [1:0] tlen, input bit [4:0] dum, input bit [1:0] dl,
                          input bit [15:0] len, input bit [31:0] adr, input bit [31:0] alt);
    b_op = op; b_dir = dir; b_cl = cl; b_al = al; b_alen = alen; b_tl = tl;
    b_tlen = tlen; b_dum = dum; b_dl = dl; b_len = len; b_adr = adr; b_alt = alt;
  endtask

  task automatic run_txn(input string tag);
    @(posedge clk);
    ttag = tag;
    req = 1;
    do @(posedge clk); while (req || q.size() != 0);
    repeat (3) @(posedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_i = 0; io_in_i = 0; wr_data_i = 0;
    op_code_i = 0; op_dir_i = 0; cmd_lanes_i = 0; adr_lanes_i = 0; adr_len_i = 0;
    alt_lanes_i = 0; alt_len_i = 0; dummy_i = 0; dat_lanes_i = 0; xfer_len_i = 0;
    adr_i = 0; alt_i = 0;
    repeat (5) @(posedge clk);
    rst_n = 1;
    repeat (6) @(posedge clk);   // R1 idle outputs checked every cycle

    // R2 R3: opcode only, one lane (write enable)
    set_desc(8'h06, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run_txn("R2 R3");

    // R6 R3: one-lane read of two bytes on IO1
    rbytes = '{8'hA5, 8'h3C};
    set_desc(8'h05, 0, 1, 0, 0, 0, 0, 0, 1, 2, 0, 0);
    run_txn("R6 R3");

    // R4 R5 R3: four-lane address, mode byte, dummy, four-lane read
    rbytes = '{8'h5A, 8'hC3, 8'h7E};
    set_desc(8'hEB, 0, 1, 3, 2, 3, 0, 4, 3, 3, 32'h0012_3456, 32'h0000_00A5);
    run_txn("R4 R5 R3");

    // R6 R4: one-lane page write, three address bytes
    wbytes = '{8'h81, 8'h42, 8'hFF};
    set_desc(8'h02, 1, 1, 1, 2, 0, 0, 0, 1, 3, 32'h00AB_CDEF, 0);
    run_txn("R6 R4");

    // R6 R4: four address bytes, four-lane write
    wbytes = '{8'h12, 8'h9E, 8'h60, 8'h0F};
    set_desc(8'h32, 1, 1, 1, 3, 0, 0, 0, 3, 4, 32'hDEAD_BEEF, 0);
    run_txn("R6 R4");

    // R3 R4: two-lane address and two mode bytes, two-lane read
    rbytes = '{8'hB4, 8'h1D};
    set_desc(8'hBB, 0, 1, 2, 1, 2, 1, 0, 2, 2, 32'h0000_7E81, 32'h0000_C35A);
    run_txn("R3 R4");

    // R10: data lanes set but byte count 0
    set_desc(8'h9F, 0, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    run_txn("R10");

    // R5 R11: dummy clocks followed by two-lane write
    wbytes = '{8'hC9, 8'h36};
    set_desc(8'h3B, 1, 1, 0, 0, 0, 0, 3, 2, 2, 0, 0);
    run_txn("R5 R11");

    // R2: every phase absent
    set_desc(8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run_txn("R2");

    // R9: a second start during a running read is ignored
    rbytes = '{8'h66, 8'h99, 8'h0F};
    set_desc(8'h03, 0, 1, 1, 2, 0, 0, 0, 1, 3, 32'h0001_0203, 0);
    @(posedge clk);
    ttag = "R9";
    req = 1;
    repeat (20) @(posedge clk);
    set_desc(8'h06, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    ign = 1;
    req = 1;
    do @(posedge clk); while (req || q.size() != 0);
    repeat (6) @(posedge clk);

    // R8: back-to-back transactions keep the chip-select gap
    set_desc(8'h04, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run_txn("R8");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule